// File: doc/BRIEF.md
# Self-Checking Active-One Output Voter

This block combines the output ports of two to four redundant processors into one set of output pins. Each processor presents two bits for every pin: a data bit and a direction bit. A pin is pulled high only when a processor sets both bits, data at 1 and direction at output. The idle pair, data 0 with direction input, is high-impedance, and a modelled pull-down turns it into a logic zero. The valid one and the valid zero differ in both bits. A single flipped flip-flop therefore cannot turn a correct zero into an active high.

The pins resolve as a wired-OR of the active-high drivers, not as a majority. Any processor that reaches the valid one state sets the pin. A processor that drives a low-impedance zero against an active high raises a clash flag on that pin. Pins named in a parameter mask are critical, and they may go high only while a separate interlock enable is true. For scrubbing, every pair is reported as a two-bit state code, and each channel has a sticky error flag for invalid pairs. The raw data and direction bits can also be read back on their own.

All outputs are registered and follow the inputs with one clock of latency. There is no state machine: each pair is classified through an enumerated state type.

Top module: `avo_voter`

## Requirements
- R1: While reset is held, and on the first edge after it, every pin, clash flag, state code, error flag and readback bit is 0.
- R2: A pin is high one clock after some channel holds data 1 with direction 1 (direction 1 means output) on it. The pairs {data 0, dir 0}, {data 1, dir 0} and {data 0, dir 1} never drive it high.
- R3: One active channel sets the pin high, whatever the other channels present.
- R4: The clash flag of a pin is set one clock after at least one channel is active on it while another channel holds {data 0, dir 1}. Otherwise the flag is clear. The interlock does not gate the clash flag.
- R5: A {data 1, dir 0} pair has no effect on the pin or on the clash flag.
- R6: A pin whose bit is set in CRIT_MASK goes high only if `arm` was high at the same sampling edge. Pins outside the mask ignore `arm`.
- R7: The state code of channel c, pin p sits at `pair_code[2*(c*NPIN+p) +: 2]` and equals {dir, data}. 00 is the valid zero, 11 the valid one, and 01 and 10 are invalid.
- R8: `chan_err[c]` sets when any pin of channel c holds an invalid pair. It stays set until `err_clr` is sampled high while no invalid pair is present. A new invalid pair wins over a clear in the same cycle.
- R9: `rb_data` and `rb_dir` return the data and direction bits one clock after they are sampled, at the same index c*NPIN+p as the inputs.
- R10: When channels release an active one at different times, the pin stays high until the last one releases, and it goes low one clock after that.
- R11: Starting from all channels at the valid zero, flipping any single data or direction bit never drives a pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_data | input | NCH*NPIN | Data bits, index c*NPIN+p |
| ch_dir | input | NCH*NPIN | Direction bits, 1 = output |
| arm | input | 1 | Interlock enable for critical pins |
| err_clr | input | 1 | Clears the sticky error flags |
| pin_out | output | NPIN | Voted pin levels |
| clash | output | NPIN | Push-pull conflict per pin |
| pair_code | output | 2*NCH*NPIN | {dir, data} state code per pair |
| chan_err | output | NCH | Sticky invalid-pair flag per channel |
| rb_data | output | NCH*NPIN | Registered readback of data bits |
| rb_dir | output | NCH*NPIN | Registered readback of direction bits |

## Verification
The bench builds the voter with four channels, four pins and CRIT_MASK 4'b0101. This is the widest ensemble the block supports. It places one interlocked pin and one free pin next to each other, so critical and non-critical pins are exercised side by side. With four channels, a pin can see an active one, a low drive and a floating one at the same time. It can also see a staggered release over four steps. Seeded random pairs cover the mixed cases, and directed sequences cover the single-bit upsets and the race between clear and error.

// File: rtl/avo_pkg.sv
package avo_pkg;

    // pair code = {dir, data}
    typedef enum logic [1:0] {
        ST_ZERO      = 2'b00,
        ST_FLOAT_ONE = 2'b01,
        ST_LOW_DRIVE = 2'b10,
        ST_ONE       = 2'b11
    } pair_state_t;

    function automatic pair_state_t pair_of(input logic data, input logic dir);
        return pair_state_t'({dir, data});
    endfunction

endpackage

// File: rtl/avo_chan_classify.sv
module avo_chan_classify
    import avo_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic [NPIN-1:0]   data,
    input  logic [NPIN-1:0]   dir,
    output logic [2*NPIN-1:0] code,
    output logic [NPIN-1:0]   active,
    output logic [NPIN-1:0]   lowdrv,
    output logic              invalid
);

    logic [NPIN-1:0] bad;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pair_state_t st;
        assign st = pair_of(data[p], dir[p]);
        assign code[2*p +: 2] = st;

        always_comb begin
            active[p] = 1'b0;
            lowdrv[p] = 1'b0;
            bad[p]    = 1'b0;
            unique case (st)
                ST_ZERO:      ;
                ST_ONE:       active[p] = 1'b1;
                ST_LOW_DRIVE: begin lowdrv[p] = 1'b1; bad[p] = 1'b1; end
                ST_FLOAT_ONE: bad[p] = 1'b1;
                default:      ;
            endcase
        end
    end

    assign invalid = |bad;

endmodule

// File: rtl/avo_pin_resolve.sv
module avo_pin_resolve #(
    parameter int   NCH  = 3,
    parameter logic CRIT = 1'b0
) (
    input  logic [NCH-1:0] active,
    input  logic [NCH-1:0] lowdrv,
    input  logic           arm,
    output logic           level,
    output logic           clash
);

    logic any_high;

    assign any_high = |active;
    assign clash    = any_high & (|lowdrv);

    if (CRIT) begin : g_crit
        assign level = any_high & arm;
    end else begin : g_free
        assign level = any_high;
    end

endmodule

// File: rtl/avo_voter.sv
module avo_voter
    import avo_pkg::*;
#(
    parameter int              NCH       = 3,
    parameter int              NPIN      = 4,
    parameter logic [NPIN-1:0] CRIT_MASK = NPIN'(1) << (NPIN - 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH*NPIN-1:0]      ch_data,
    input  logic [NCH*NPIN-1:0]      ch_dir,
    input  logic                     arm,
    input  logic                     err_clr,
    output logic [NPIN-1:0]          pin_out,
    output logic [NPIN-1:0]          clash,
    output logic [2*NCH*NPIN-1:0]    pair_code,
    output logic [NCH-1:0]           chan_err,
    output logic [NCH*NPIN-1:0]      rb_data,
    output logic [NCH*NPIN-1:0]      rb_dir
);

    localparam int NBIT = NCH * NPIN;

    logic [2*NBIT-1:0] code_d;
    logic [NBIT-1:0]   act_cp;
    logic [NBIT-1:0]   low_cp;
    logic [NCH-1:0]    inv_d;
    logic [NPIN-1:0]   level_d;
    logic [NPIN-1:0]   clash_d;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        avo_chan_classify #(.NPIN(NPIN)) u_cls (
            .data    (ch_data[c*NPIN +: NPIN]),
            .dir     (ch_dir[c*NPIN +: NPIN]),
            .code    (code_d[2*c*NPIN +: 2*NPIN]),
            .active  (act_cp[c*NPIN +: NPIN]),
            .lowdrv  (low_cp[c*NPIN +: NPIN]),
            .invalid (inv_d[c])
        );
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [NCH-1:0] act_pc;
        logic [NCH-1:0] low_pc;
        for (genvar c = 0; c < NCH; c++) begin : g_tr
            assign act_pc[c] = act_cp[c*NPIN + p];
            assign low_pc[c] = low_cp[c*NPIN + p];
        end
        avo_pin_resolve #(.NCH(NCH), .CRIT(CRIT_MASK[p])) u_res (
            .active (act_pc),
            .lowdrv (low_pc),
            .arm    (arm),
            .level  (level_d[p]),
            .clash  (clash_d[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_out   <= '0;
            clash     <= '0;
            pair_code <= '0;
            chan_err  <= '0;
            rb_data   <= '0;
            rb_dir    <= '0;
        end else begin
            pin_out   <= level_d;
            clash     <= clash_d;
            pair_code <= code_d;
            chan_err  <= (err_clr ? '0 : chan_err) | inv_d;
            rb_data   <= ch_data;
            rb_dir    <= ch_dir;
        end
    end

endmodule

// File: rtl/avo_voter_chk.sv
module avo_voter_chk #(
    parameter int              NCH       = 3,
    parameter int              NPIN      = 4,
    parameter logic [NPIN-1:0] CRIT_MASK = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  arm,
    input logic                  err_clr,
    input logic [NPIN-1:0]       pin_out,
    input logic [NPIN-1:0]       clash,
    input logic [2*NCH*NPIN-1:0] pair_code,
    input logic [NCH-1:0]        chan_err
);

    for (genvar p = 0; p < NPIN; p++) begin : g_p
        logic one_seen;
        always_comb begin
            one_seen = 1'b0;
            for (int c = 0; c < NCH; c++)
                if (pair_code[2*(c*NPIN+p) +: 2] == 2'b11) one_seen = 1'b1;
        end

        // R2
        only_valid_one_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pin_out[p] |-> one_seen);

        if (!CRIT_MASK[p]) begin : g_free
            // R3
            any_one_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                one_seen |-> pin_out[p]);
            // R4
            clash_has_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clash[p] |-> pin_out[p]);
        end else begin : g_crit
            // R6
            interlock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pin_out[p] |-> $past(arm));
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_c
        logic inv_seen;
        always_comb begin
            inv_seen = 1'b0;
            for (int p = 0; p < NPIN; p++)
                if (^pair_code[2*(c*NPIN+p) +: 2]) inv_seen = 1'b1;
        end

        // R8
        err_on_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            inv_seen |-> chan_err[c]);

        // R8
        err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_err[c] && !err_clr |=> chan_err[c]);
    end

endmodule

bind avo_voter avo_voter_chk #(
    .NCH       (NCH),
    .NPIN      (NPIN),
    .CRIT_MASK (CRIT_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .err_clr   (err_clr),
    .pin_out   (pin_out),
    .clash     (clash),
    .pair_code (pair_code),
    .chan_err  (chan_err)
);

// File: tb/tb_avo_voter.sv
`timescale 1ns/1ps
module tb_avo_voter;

    localparam int              NCH  = 4;
    localparam int              NPIN = 4;
    localparam int              NBIT = NCH * NPIN;
    localparam logic [NPIN-1:0] CRIT = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NBIT-1:0] ch_data = '0;
    logic [NBIT-1:0] ch_dir = '0;
    logic arm = 1'b0;
    logic err_clr = 1'b0;
    logic [NPIN-1:0] pin_out, clash;
    logic [2*NBIT-1:0] pair_code;
    logic [NCH-1:0] chan_err;
    logic [NBIT-1:0] rb_data, rb_dir;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [NCH-1:0] m_err = '0;

    always #2 clk = ~clk;

    avo_voter #(.NCH(NCH), .NPIN(NPIN), .CRIT_MASK(CRIT)) dut (
        .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_dir(ch_dir),
        .arm(arm), .err_clr(err_clr), .pin_out(pin_out), .clash(clash),
        .pair_code(pair_code), .chan_err(chan_err), .rb_data(rb_data), .rb_dir(rb_dir)
    );

    function automatic logic [NPIN-1:0] exp_pin(input logic [NBIT-1:0] d, r, input logic a);
        logic [NPIN-1:0] v = '0;
        for (int p = 0; p < NPIN; p++) begin
            logic any = 1'b0;
            for (int c = 0; c < NCH; c++) any |= d[c*NPIN+p] & r[c*NPIN+p];
            v[p] = any & (!CRIT[p] | a);
        end
        return v;
    endfunction

    function automatic logic [NPIN-1:0] exp_clash(input logic [NBIT-1:0] d, r);
        logic [NPIN-1:0] v = '0;
        for (int p = 0; p < NPIN; p++) begin
            logic hi = 1'b0, lo = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                hi |= d[c*NPIN+p] & r[c*NPIN+p];
                lo |= !d[c*NPIN+p] & r[c*NPIN+p];
            end
            v[p] = hi & lo;
        end
        return v;
    endfunction

    function automatic logic [2*NBIT-1:0] exp_code(input logic [NBIT-1:0] d, r);
        logic [2*NBIT-1:0] v;
        for (int i = 0; i < NBIT; i++) v[2*i +: 2] = {r[i], d[i]};
        return v;
    endfunction

    function automatic logic [NCH-1:0] exp_inv(input logic [NBIT-1:0] d, r);
        logic [NCH-1:0] v = '0;
        for (int c = 0; c < NCH; c++) v[c] = |(d[c*NPIN +: NPIN] ^ r[c*NPIN +: NPIN]);
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply(input logic [NBIT-1:0] d, r, input logic a, c);
        @(negedge clk);
        ch_data = d; ch_dir = r; arm = a; err_clr = c;
        @(posedge clk); #1;
        m_err = (c ? '0 : m_err) | exp_inv(d, r);
        chk("R2/R3/R6 pin_out", 64'(pin_out), 64'(exp_pin(d, r, a)));
        chk("R4 clash", 64'(clash), 64'(exp_clash(d, r)));
        chk("R7 pair_code", 64'(pair_code), 64'(exp_code(d, r)));
        chk("R8 chan_err", 64'(chan_err), 64'(m_err));
        chk("R9 rb_data", 64'(rb_data), 64'(d));
        chk("R9 rb_dir", 64'(rb_dir), 64'(r));
    endtask

    function automatic logic [NBIT-1:0] bitat(input int c, input int p);
        return NBIT'(1) << (c*NPIN + p);
    endfunction

    initial begin
        void'($urandom(32'd1977));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 pin_out", 64'(pin_out), 0);
        chk("R1 clash", 64'(clash), 0);
        chk("R1 pair_code", 64'(pair_code), 0);
        chk("R1 chan_err", 64'(chan_err), 0);
        chk("R1 readback", 64'({rb_data, rb_dir}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 first edge pins", 64'(pin_out), 0);

        // R3: one active channel on free pin 1 against three zeros
        apply(bitat(0,1), bitat(0,1), 1'b0, 1'b0);
        chk("R3 single one wins", 64'(pin_out[1]), 1);

        // R5: floating one alone does nothing, then beside an active one
        apply(bitat(2,1), '0, 1'b0, 1'b1);
        chk("R5 float one ignored", 64'({pin_out[1], clash[1]}), 0);
        apply(bitat(2,1) | bitat(0,1), bitat(0,1), 1'b0, 1'b0);
        chk("R5 float one no clash", 64'({pin_out[1], clash[1]}), 64'b10);

        // R4: active one against low drive on pin 3
        apply(bitat(0,3), bitat(0,3) | bitat(1,3), 1'b0, 1'b1);
        chk("R4 clash flagged", 64'(clash[3]), 1);

        // R6: critical pin 0 with and without arm; clash independent of arm
        apply(bitat(0,0), bitat(0,0) | bitat(3,0), 1'b0, 1'b1);
        chk("R6 unarmed low", 64'({pin_out[0], clash[0]}), 64'b01);
        apply(bitat(0,0), bitat(0,0), 1'b1, 1'b1);
        chk("R6 armed high", 64'(pin_out[0]), 1);

        // R10: staggered release on pin 1
        begin
            logic [NBIT-1:0] m = '0;
            for (int c = 0; c < NCH; c++) m |= bitat(c, 1);
            apply(m, m, 1'b0, 1'b1);
            for (int c = 0; c < NCH; c++) begin
                m &= ~bitat(c, 1);
                apply(m, m, 1'b0, 1'b1);
                chk("R10 widening", 64'(pin_out[1]), (c == NCH-1) ? 0 : 1);
            end
        end

        // R11: single upset from valid zero
        for (int i = 0; i < NBIT; i++) begin
            apply(NBIT'(1) << i, '0, 1'b1, 1'b1);
            chk("R11 data upset", 64'(pin_out), 0);
            apply('0, NBIT'(1) << i, 1'b1, 1'b1);
            chk("R11 dir upset", 64'(pin_out), 0);
        end

        // R8: set wins over clear, sticky, then clears
        apply(bitat(2,2), '0, 1'b0, 1'b1);
        chk("R8 set beats clear", 64'(chan_err[2]), 1);
        apply('0, '0, 1'b0, 1'b0);
        chk("R8 sticky", 64'(chan_err[2]), 1);
        apply('0, '0, 1'b0, 1'b1);
        chk("R8 cleared", 64'(chan_err), 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [NBIT-1:0] d = NBIT'($urandom);
            logic [NBIT-1:0] r = NBIT'($urandom);
            if (n % 3 == 0) r = d;
            if (n % 5 == 0) d &= NBIT'($urandom);
            apply(d, r, 1'($urandom), ($urandom % 8) == 0);
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule